// File: doc/BRIEF.md
# Multichannel AC Power Metering Datapath

This block turns interleaved voltage and current samples from up to eight channel pairs into four smoothed figures per channel: mean-square voltage, mean-square current, real power and signed reactive power. Each sample carries a channel index. One shared arithmetic path serves all channels. It keeps a private sample history for each channel, so channels never share state.

Reactive power is formed without timing zero crossings. A fixed antisymmetric 31-tap filter shifts the voltage stream by a quarter cycle. The current stream passes through a 15-sample delay line so that it lines up with the filter's centre tap. Their product is then smoothed. Each of the four products feeds a first-order shift-based lowpass. Square roots, phase angles and frequency tracking are left to software. The host pulses a capture strobe to freeze all 32 results into a snapshot bank, then reads them one at a time through a channel and quantity select.

Top module: `acpwr_meter`

## Requirements
- R1: After reset, every channel and quantity read returns 0.
- R2: On each valid sample for channel c, the mean-square voltage value y of c becomes y + floor((v*v - y) / 2^LPF_K), with LPF_K = 4 by default. This value is never negative.
- R3: On each valid sample for channel c, the mean-square current value of c is updated with the same rule, using i*i.
- R4: On each valid sample for channel c, the real power value of c is updated with the same rule, using v*i.
- R5: On each valid sample for channel c, the reactive power value of c is updated with the same rule, using q*d, where q = floor(S / 2^15) and S = sum over m = 1,3,...,15 of c_m * (v[15-m] - v[15+m]). Here c_m = round(65536/(pi*m)), and v[j] is the voltage of channel c from j samples ago: v[0] is the current sample, and samples that were never received count as 0. The result is signed.
- R6: The current factor d in R5 is the current sample of the same channel from exactly 15 samples earlier, or 0 if fewer than 15 samples have been received.
- R7: A sample for one channel leaves the accumulators and histories of every other channel unchanged.
- R8: A clock edge with cap_stb high copies all accumulators into the snapshot bank. rd_data shows only the snapshot, so it does not change between captures while rd_ch and rd_sel are held.
- R9: rd_sel selects the quantity: 0 mean-square voltage, 1 mean-square current, 2 real power, 3 reactive power. rd_ch selects the channel. rd_data is a 48-bit two's-complement value.
- R10: A cycle without smp_vld changes no accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample pair |
| smp_ch | input | 3 | Channel index of the sample pair |
| smp_v | input | 16 | Signed voltage sample |
| smp_i | input | 16 | Signed current sample |
| cap_stb | input | 1 | Copies all results into the snapshot bank |
| rd_ch | input | 3 | Channel to read |
| rd_sel | input | 2 | Quantity to read (encoding in R9) |
| rd_data | output | 48 | Selected snapshot value, signed |

## Verification
On every cycle, the assertions check the following: the reset value is zero; the read port stays stable between captures; idle cycles leave the accumulators untouched; channel 0 is isolated from samples on other channels; and the mean-square accumulators stay non-negative. The numeric results cannot be shown by a property. These are the lowpass arithmetic, the quarter-cycle filter with its coefficients, and the exact 15-sample alignment of the current path. The bench's scenarios check them against an independent model: a table of mixed-channel samples, a sine run, a current impulse, and full-scale inputs.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int SW    = 16;            // sample width
  localparam int AW    = 48;            // accumulator width
  localparam int NQ    = 4;             // quantities per channel
  localparam int NTAP  = 31;            // quadrature filter length
  localparam int GDLY  = (NTAP - 1) / 2; // group delay in samples
  localparam int NCOEF = (GDLY + 1) / 2; // nonzero odd offsets
  localparam int CSH   = 15;            // coefficient fraction bits
  localparam int SUMW  = 40;            // quadrature sum width
  localparam int QW    = 20;            // quadrature output width

  typedef enum logic [1:0] {
    QTY_VSQ   = 2'd0,
    QTY_ISQ   = 2'd1,
    QTY_REAL  = 2'd2,
    QTY_REACT = 2'd3
  } qty_e;

  // round(65536 / (pi * (2*idx+1)))
  function automatic logic signed [SW-1:0] quad_coef(input int idx);
    case (idx)
      0:       return 16'sd20861;
      1:       return 16'sd6954;
      2:       return 16'sd4172;
      3:       return 16'sd2980;
      4:       return 16'sd2318;
      5:       return 16'sd1896;
      6:       return 16'sd1605;
      default: return 16'sd1391;
    endcase
  endfunction

  function automatic logic signed [AW-1:0] smul(input logic signed [AW-1:0] a,
                                                input logic signed [AW-1:0] b);
    return a * b;
  endfunction

  function automatic logic signed [AW-1:0] lpf_step(input logic signed [AW-1:0] y,
                                                    input logic signed [AW-1:0] x,
                                                    input int k);
    return y + ((x - y) >>> k);
  endfunction
endpackage

// File: rtl/acp_hist.sv
module acp_hist #(
  parameter int NCH   = 8,
  parameter int DEPTH = 15,
  parameter int W     = 16,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CW-1:0]              wr_ch,
  input  logic [W-1:0]               din,
  output logic [DEPTH-1:0][W-1:0]    taps
);
  logic [NCH-1:0][DEPTH-1:0][W-1:0] line_q;

  // taps[j] is the sample j+1 positions back for the addressed channel
  assign taps = line_q[wr_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line_q <= '0;
    else if (wr_en) line_q[wr_ch] <= {line_q[wr_ch][DEPTH-2:0], din};
  end
endmodule

// File: rtl/acp_quad.sv
module acp_quad
  import acp_pkg::*;
(
  input  logic signed [SW-1:0]      v_now,
  input  logic [NTAP-2:0][SW-1:0]   v_old,
  output logic signed [QW-1:0]      q
);
  logic signed [SW-1:0]   win [NTAP];
  logic signed [SW:0]     diff;
  logic signed [SUMW-1:0] prod;
  logic signed [SUMW-1:0] sum;
  logic signed [SUMW-1:0] sh;

  assign win[0] = v_now;
  for (genvar j = 1; j < NTAP; j++) begin : g_win
    assign win[j] = v_old[j-1];
  end

  // antisymmetric odd-tap sum around the centre sample
  always_comb begin
    sum  = '0;
    diff = '0;
    prod = '0;
    for (int m = 0; m < NCOEF; m++) begin
      diff = win[GDLY - (2*m + 1)] - win[GDLY + (2*m + 1)];
      prod = diff * quad_coef(m);
      sum  = sum + prod;
    end
    sh = sum >>> CSH;
    q  = sh[QW-1:0];
  end
endmodule

// File: rtl/acp_lpf.sv
module acp_lpf
  import acp_pkg::*;
#(
  parameter int NCH = 8,
  parameter int K   = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [CW-1:0]             ch,
  input  logic signed [AW-1:0]      x,
  output logic [NCH-1:0][AW-1:0]    y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y <= '0;
    else if (en) y[ch] <= lpf_step(y[ch], x, K);
  end
endmodule

// File: rtl/acpwr_meter.sv
module acpwr_meter
  import acp_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int LPF_K = 4,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic [CW-1:0]        smp_ch,
  input  logic signed [SW-1:0] smp_v,
  input  logic signed [SW-1:0] smp_i,
  input  logic                 cap_stb,
  input  logic [CW-1:0]        rd_ch,
  input  logic [1:0]           rd_sel,
  output logic [AW-1:0]        rd_data
);
  // named events for the checker
  logic          upd_fire;
  logic [CW-1:0] upd_ch;
  assign upd_fire = smp_vld;
  assign upd_ch   = smp_ch;

  logic [NTAP-2:0][SW-1:0] v_taps;
  logic [GDLY-1:0][SW-1:0] i_taps;
  logic signed [SW-1:0]    i_dly;
  logic signed [QW-1:0]    v_quad;

  acp_hist #(.NCH(NCH), .DEPTH(NTAP-1), .W(SW)) u_vhist (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_fire), .wr_ch(upd_ch),
    .din(smp_v), .taps(v_taps));

  acp_hist #(.NCH(NCH), .DEPTH(GDLY), .W(SW)) u_ihist (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_fire), .wr_ch(upd_ch),
    .din(smp_i), .taps(i_taps));

  assign i_dly = i_taps[GDLY-1];

  acp_quad u_quad (.v_now(smp_v), .v_old(v_taps), .q(v_quad));

  logic signed [AW-1:0] lane_x [NQ];
  always_comb begin
    lane_x[QTY_VSQ]   = smul(smp_v, smp_v);
    lane_x[QTY_ISQ]   = smul(smp_i, smp_i);
    lane_x[QTY_REAL]  = smul(smp_v, smp_i);
    lane_x[QTY_REACT] = smul(v_quad, i_dly);
  end

  logic [NQ-1:0][NCH-1:0][AW-1:0] acc_all;
  for (genvar g = 0; g < NQ; g++) begin : g_lane
    acp_lpf #(.NCH(NCH), .K(LPF_K)) u_lpf (
      .clk(clk), .rst_n(rst_n), .en(upd_fire), .ch(upd_ch),
      .x(lane_x[g]), .y(acc_all[g]));
  end

  logic [NQ-1:0][NCH-1:0][AW-1:0] snap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (cap_stb) snap_q <= acc_all;
  end

  assign rd_data = snap_q[rd_sel][rd_ch];
endmodule

// File: rtl/acpwr_meter_chk.sv
module acpwr_meter_chk
  import acp_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cap_stb,
  input logic [CW-1:0]                 rd_ch,
  input logic [1:0]                    rd_sel,
  input logic [AW-1:0]                 rd_data,
  input logic                          upd_fire,
  input logic [CW-1:0]                 upd_ch,
  input logic [NQ-1:0][NCH-1:0][AW-1:0] acc_all
);
  logic [NQ*AW-1:0] ch0_vals;
  for (genvar g = 0; g < NQ; g++) begin : g_ch0
    assign ch0_vals[g*AW +: AW] = acc_all[g][0];
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0); // R1

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> (($stable(rd_ch) && $stable(rd_sel)) -> $stable(rd_data))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(acc_all)); // R10

  AST_CH_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && upd_ch != '0) |=> $stable(ch0_vals)); // R7

  for (genvar c = 0; c < NCH; c++) begin : g_ms
    AST_MS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_all[QTY_VSQ][c][AW-1] && !acc_all[QTY_ISQ][c][AW-1]); // R2
  end
endmodule

bind acpwr_meter acpwr_meter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .rd_ch(rd_ch),
  .rd_sel(rd_sel), .rd_data(rd_data), .upd_fire(upd_fire),
  .upd_ch(upd_ch), .acc_all(acc_all));

// File: tb/sim_acpwr_meter.sv
`timescale 1ns/1ps
module sim_acpwr_meter;
  localparam int K = 4;
  localparam int NV = 16;
  // {ch[2:0], v[15:0], i[15:0]}
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 16'sd1200,   16'sd300},
    {3'd1, -16'sd5000,  16'sd2500},
    {3'd2, 16'sd32767,  -16'sd32768},
    {3'd0, 16'sd2400,   16'sd600},
    {3'd5, -16'sd100,   -16'sd900},
    {3'd6, 16'sd7777,   16'sd1},
    {3'd1, -16'sd4000,  16'sd2000},
    {3'd7, 16'sd15000,  -16'sd15000},
    {3'd0, 16'sd3600,   16'sd900},
    {3'd2, -16'sd32768, 16'sd32767},
    {3'd3, 16'sd12345,  16'sd4321},
    {3'd4, -16'sd2222,  16'sd3333},
    {3'd0, 16'sd4800,   -16'sd1200},
    {3'd6, 16'sd0,      16'sd20000},
    {3'd1, 16'sd3000,   -16'sd1500},
    {3'd7, -16'sd9000,  16'sd9000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [2:0] smp_ch = '0;
  logic signed [15:0] smp_v = '0;
  logic signed [15:0] smp_i = '0;
  logic cap_stb = 1'b0;
  logic [2:0] rd_ch = '0;
  logic [1:0] rd_sel = '0;
  logic [47:0] rd_data;

  always #5 clk = ~clk;

  acpwr_meter #(.NCH(8), .LPF_K(K)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ch(smp_ch),
    .smp_v(smp_v), .smp_i(smp_i), .cap_stb(cap_stb), .rd_ch(rd_ch),
    .rd_sel(rd_sel), .rd_data(rd_data));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int     vw [8][31];
  int     iw [8][16];
  longint macc [4][8];
  longint msnap [4][8];
  string  seltag [4] = '{"R2", "R3", "R4", "R5"};

  task automatic model_clear();
    for (int c = 0; c < 8; c++) begin
      for (int j = 0; j < 31; j++) vw[c][j] = 0;
      for (int j = 0; j < 16; j++) iw[c][j] = 0;
      for (int s = 0; s < 4; s++) begin macc[s][c] = 0; msnap[s][c] = 0; end
    end
  endtask

  task automatic model_sample(input int c, input int v, input int i);
    longint s, q, x [4];
    for (int j = 30; j > 0; j--) vw[c][j] = vw[c][j-1];
    vw[c][0] = v;
    for (int j = 15; j > 0; j--) iw[c][j] = iw[c][j-1];
    iw[c][0] = i;
    s = 0;
    for (int m = 1; m <= 15; m += 2)
      s += longint'($rtoi(65536.0 / (3.14159265358979 * m) + 0.5)) *
           longint'(vw[c][15-m] - vw[c][15+m]);
    q = s >>> 15;
    x[0] = longint'(v) * v;
    x[1] = longint'(i) * i;
    x[2] = longint'(v) * i;
    x[3] = q * iw[c][15];
    for (int k = 0; k < 4; k++) macc[k][c] = macc[k][c] + ((x[k] - macc[k][c]) >>> K);
  endtask

  task automatic drive(input int c, input int v, input int i);
    @(negedge clk);
    smp_vld = 1'b1; smp_ch = 3'(c); smp_v = 16'(v); smp_i = 16'(i);
    @(negedge clk);
    smp_vld = 1'b0;
    model_sample(c, v, i);
  endtask

  task automatic capture();
    @(negedge clk);
    cap_stb = 1'b1;
    @(negedge clk);
    cap_stb = 1'b0;
    msnap = macc;
  endtask

  task automatic check_all(input int focus, input string over);
    longint got;
    string tag;
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        rd_ch = 3'(c); rd_sel = 2'(s);
        #1;
        got = longint'($signed(rd_data));
        tag = (over != "") ? over : ((focus >= 0 && c != focus) ? "R7" : seltag[s]);
        checks++;
        if (got !== msnap[s][c]) begin
          errors++;
          $display("FAIL %s ch%0d sel%0d (R9 read) actual %0d expected %0d",
                   tag, c, s, got, msnap[s][c]);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_all(-1, "R1");

    // table walk: R2 R3 R4 R5 R9 on mixed channels
    for (int n = 0; n < NV; n++)
      drive(int'(VEC[n][34:32]), int'($signed(VEC[n][31:16])), int'($signed(VEC[n][15:0])));
    capture();
    check_all(-1, "");

    // R8: updates without capture stay hidden
    drive(1, 11111, -2222);
    drive(1, -3333, 4444);
    check_all(-1, "R8");
    capture();
    check_all(-1, "");

    // R10: idle cycles change nothing
    repeat (6) @(negedge clk);
    capture();
    check_all(-1, "R10");

    // sine run on channel 3, other channels checked as R7
    for (int n = 0; n < 60; n++) begin
      real ph;
      ph = 2.0 * 3.14159265358979 * n / 40.0;
      drive(3, $rtoi(30000.0 * $sin(ph)), $rtoi(20000.0 * $sin(ph - 0.5)));
    end
    capture();
    check_all(3, "");

    // R6: current impulse on channel 4 reaches the reactive lane 15 samples later
    drive(4, 20000, 1000);
    for (int n = 0; n < 14; n++) drive(4, 20000 - 1000 * n, 0);
    capture();
    check_all(4, "");
    drive(4, -5000, 0);
    capture();
    check_all(4, "R6");

    // full-scale inputs on channel 7
    for (int n = 0; n < 40; n++) drive(7, -32768, (n % 2 == 0) ? 32767 : -32768);
    capture();
    check_all(7, "");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule